// File: doc/BRIEF.md
# Paged Edge-Detect Digital I/O Controller

This block is a byte-wide register interface to 48 digital lines, grouped as six 8-bit ports inside a 16-byte address window. Each line behaves like an open-drain pin with inverted sense. Writing a 1 to a port bit pulls the line low. Writing a 0 releases it, so it floats high and can be sampled as an input. Reading a port returns the inverted level of the pin after it has been synchronised.

The lines of the three lowest ports (24 lines) can also detect edges. Each of these lines has a polarity bit (rising or falling) and an enable bit. A detected edge sets a sticky bit in that port's capture register, and software later clears it. The polarity, enable and capture registers share three addresses, and a page field chooses which of them is visible there. The same page/lock register also holds one lock bit per port, which protects that port's output bits from writes. A summary register reports one pending bit per edge-capable port, and one interrupt output is high while any of those bits is set.

Reads are combinational from the address. Writes take effect at the rising clock edge on which `bus_wr` is high.

Top module: `dio_edge_ctrl`

## Requirements
- R1: After reset all output bits are 0 (no line pulled low), the lock bits are 0, the page is 0, all polarity, enable and capture bits are 0, and `irq` is low.
- R2: A write to offset p (0..5) stores the byte as port p's output. A bit of 1 drives `pin_pull_low[8p+b]` high from the next cycle, and a bit of 0 releases the line.
- R3: A read of offset p (0..5) returns the bitwise inverse of `pin_in[8p+7:8p]`, taken through a two-flop synchroniser. A pin change is seen after two rising clock edges.
- R4: Offset 7 is the page/lock register. Bits [5:0] are the lock bits, with bit p locking port p. Bits [7:6] are the page: 0 none, 1 polarity, 2 enable, 3 capture. A write sets both fields and a read returns both.
- R5: A write to offset 15 loads only the page field, from data bits [1:0], and leaves the lock bits unchanged. Offset 15 reads as 0, and so do offsets 11 to 14.
- R6: A write to the data register of a locked port is ignored: its output bits keep their value.
- R7: Offsets 8, 9 and 10 reach the paged register of ports 0, 1 and 2 in the bank the page selects. With page 0 these offsets read as 0 and ignore writes.
- R8: An edge on an enabled line of ports 0 to 2 sets that line's capture bit. A polarity bit of 1 selects the rising edge and 0 selects the falling edge. The bit is readable after the third rising clock edge that follows the pin change. An edge on a disabled line, or of the opposite direction, is not captured.
- R9: A write to a capture register keeps only the bits that are 1 in the data, so writing 0 clears the port. An edge that is detected in the same cycle as the write is still captured.
- R10: Offset 6 returns one pending bit per port in bits [2:0], and that bit is 1 when any capture bit of the port is set. Bits [7:3] read as 0. `irq` is high exactly while some pending bit is set.
- R11: Ports 3 to 5 never capture edges. Toggling their pins leaves the pending register and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Sensed pin levels |
| pin_pull_low | output | 48 | 1 pulls the corresponding pin low |
| irq | output | 1 | High while any capture bit is set |

## Verification
Every cycle, the assertions check the following:
- A write to a locked port leaves its outputs unchanged.
- A page-only write leaves the lock bits unchanged.
- Each detected edge is present in its capture register one cycle later, even when a clear is written in the same cycle.
- No capture bit appears without a detected edge.
- `irq` falls only after a capture-register write.

Only the bench scenarios can show the following:
- The three-edge latency from a pin change to a readable capture bit.
- The polarity selection under mixed random pin patterns.
- The inverted port readback.
- That ports 3 to 5 never raise a pending bit.

// File: rtl/dio_pkg.sv
package dio_pkg;
    parameter int PORT_W     = 8;
    parameter int NUM_PORTS  = 6;
    parameter int EDGE_PORTS = 3;
    parameter int ADDR_W     = 4;
    parameter int SYNC_W     = PORT_W * NUM_PORTS;

    localparam logic [ADDR_W-1:0] OFF_PEND   = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_PGLK   = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_PAGED0 = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_PGSEL  = 4'd15;

    typedef enum logic [1:0] {
        PG_NONE  = 2'd0,
        PG_POL   = 2'd1,
        PG_ENAB  = 2'd2,
        PG_IDENT = 2'd3
    } page_e;

    typedef struct packed {
        page_e                  page;
        logic [NUM_PORTS-1:0]   lock;
    } pagelock_t;

    function automatic logic [ADDR_W-1:0] data_off(input int p);
        return ADDR_W'(p);
    endfunction

    function automatic logic [ADDR_W-1:0] paged_off(input int p);
        return OFF_PAGED0 + ADDR_W'(p);
    endfunction

    function automatic logic [PORT_W-1:0] edge_hits(
        input logic [PORT_W-1:0] cur,
        input logic [PORT_W-1:0] prev,
        input logic [PORT_W-1:0] pol,
        input logic [PORT_W-1:0] en);
        return en & ((pol & cur & ~prev) | (~pol & ~cur & prev));
    endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/dio_out_port.sv
module dio_out_port
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              locked,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] pull_low
);
    always_ff @(posedge clk) begin
        if (rst)
            pull_low <= '0;
        else if (wr && !locked)
            pull_low <= wdata;
    end

    // R6
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && locked) |=> $stable(pull_low));
endmodule

// File: rtl/dio_edge_port.sv
module dio_edge_port
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] cur,
    input  logic              wr_pol,
    input  logic              wr_enab,
    input  logic              wr_ident,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] pol,
    output logic [PORT_W-1:0] enab,
    output logic [PORT_W-1:0] ident
);
    logic [PORT_W-1:0] prev;
    logic [PORT_W-1:0] hit;

    assign hit = edge_hits(cur, prev, pol, enab);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= '0;
            pol   <= '0;
            enab  <= '0;
            ident <= '0;
        end else begin
            prev <= cur;
            if (wr_pol)  pol  <= wdata;
            if (wr_enab) enab <= wdata;
            if (wr_ident)
                ident <= (ident & wdata) | hit;
            else
                ident <= ident | hit;
        end
    end

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((ident & $past(hit)) == $past(hit)));

    // R8
    no_spurious_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ((ident & ~$past(ident) & ~$past(hit)) == '0));
endmodule

// File: rtl/dio_edge_ctrl.sv
module dio_edge_ctrl
    import dio_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [PORT_W-1:0]          bus_wdata,
    output logic [PORT_W-1:0]          bus_rdata,
    input  logic [SYNC_W-1:0]          pin_in,
    output logic [SYNC_W-1:0]          pin_pull_low,
    output logic                       irq
);
    pagelock_t              pglk;
    logic [SYNC_W-1:0]      pin_s;
    logic [PORT_W-1:0]      pol_r   [EDGE_PORTS];
    logic [PORT_W-1:0]      enab_r  [EDGE_PORTS];
    logic [PORT_W-1:0]      ident_r [EDGE_PORTS];
    logic [EDGE_PORTS-1:0]  pend;
    logic                   ident_wr_any;

    dio_sync #(.W(SYNC_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pglk <= '{page: PG_NONE, lock: '0};
        end else if (bus_wr && bus_addr == OFF_PGLK) begin
            pglk <= pagelock_t'(bus_wdata);
        end else if (bus_wr && bus_addr == OFF_PGSEL) begin
            pglk.page <= page_e'(bus_wdata[1:0]);
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
        dio_out_port u_out (
            .clk      (clk),
            .rst      (rst),
            .wr       (bus_wr && bus_addr == data_off(p)),
            .locked   (pglk.lock[p]),
            .wdata    (bus_wdata),
            .pull_low (pin_pull_low[p*PORT_W +: PORT_W])
        );
    end

    logic [EDGE_PORTS-1:0] ident_wr_vec;

    for (genvar p = 0; p < EDGE_PORTS; p++) begin : g_edge
        logic paged_hit;
        assign paged_hit = bus_wr && bus_addr == paged_off(p);
        assign ident_wr_vec[p] = paged_hit && pglk.page == PG_IDENT;

        dio_edge_port u_edge (
            .clk      (clk),
            .rst      (rst),
            .cur      (pin_s[p*PORT_W +: PORT_W]),
            .wr_pol   (paged_hit && pglk.page == PG_POL),
            .wr_enab  (paged_hit && pglk.page == PG_ENAB),
            .wr_ident (ident_wr_vec[p]),
            .wdata    (bus_wdata),
            .pol      (pol_r[p]),
            .enab     (enab_r[p]),
            .ident    (ident_r[p])
        );
        assign pend[p] = |ident_r[p];
    end

    assign ident_wr_any = |ident_wr_vec;
    assign irq = |pend;

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == data_off(p))
                bus_rdata = ~pin_s[p*PORT_W +: PORT_W];
        end
        for (int p = 0; p < EDGE_PORTS; p++) begin
            if (bus_addr == paged_off(p)) begin
                case (pglk.page)
                    PG_POL:   bus_rdata = pol_r[p];
                    PG_ENAB:  bus_rdata = enab_r[p];
                    PG_IDENT: bus_rdata = ident_r[p];
                    default:  bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == OFF_PEND)
            bus_rdata = PORT_W'(pend);
        if (bus_addr == OFF_PGLK)
            bus_rdata = pglk;
    end

    // R5
    pgsel_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PGSEL) |=> $stable(pglk.lock));

    // R10
    irq_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(ident_wr_any));

    // R7
    page0_paged_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && pglk.page == PG_NONE) |=> ($stable(pol_r[0]) && $stable(enab_r[0])));
endmodule

// File: tb/tb_dio_edge_ctrl.sv
module tb_dio_edge_ctrl;
    import dio_pkg::*;

    logic              clk = 0;
    logic              rst;
    logic [3:0]        bus_addr;
    logic              bus_wr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;
    logic [47:0]       pin_in;
    logic [47:0]       pin_pull_low;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_pol  [3];
    logic [7:0] m_en   [3];
    logic [7:0] m_id   [3];

    always #2.5 clk = ~clk;

    dio_edge_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_pull_low(pin_pull_low), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_hits(input logic [7:0] nw, input logic [7:0] old,
                                            input logic [7:0] pl, input logic [7:0] en);
        return en & ((pl & nw & ~old) | (~pl & ~nw & old));
    endfunction

    function automatic logic [7:0] exp_pend();
        logic [7:0] r = 0;
        for (int p = 0; p < 3; p++) r[p] = |m_id[p];
        return r;
    endfunction

    task automatic set_pins(input logic [47:0] v);
        logic [47:0] old = pin_in;
        for (int p = 0; p < 3; p++)
            m_id[p] |= exp_hits(v[p*8 +: 8], old[p*8 +: 8], m_pol[p], m_en[p]);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_ids(input string tag);
        logic [7:0] d;
        wr(OFF_PGSEL, 8'd3);
        for (int p = 0; p < 3; p++) begin
            rd(paged_off(p), d);
            chk(d == m_id[p], {tag, " R8 capture"}, d, m_id[p]);
        end
        rd(OFF_PEND, d);
        chk(d == exp_pend(), {tag, " R10 pending"}, d, exp_pend());
        chk(irq == (exp_pend() != 0), {tag, " R10 irq"}, irq, exp_pend() != 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [47:0] v;
        void'($urandom(32'h5eed));
        for (int p = 0; p < 3; p++) begin m_pol[p] = 0; m_en[p] = 0; m_id[p] = 0; end
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = '1;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(pin_pull_low == 0, "R1 outputs", pin_pull_low, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rd(OFF_PGLK, d); chk(d == 0, "R1 pagelock", d, 0);
        rd(paged_off(0), d); chk(d == 0, "R1 paged page0", d, 0);
        wr(OFF_PGSEL, 8'd3);
        rd(paged_off(1), d); chk(d == 0, "R1 ident", d, 0);

        // R2 output drive
        wr(data_off(4), 8'hA5);
        chk(pin_pull_low[39:32] == 8'hA5, "R2 drive", pin_pull_low[39:32], 8'hA5);
        wr(data_off(4), 8'h00);
        chk(pin_pull_low[39:32] == 8'h00, "R2 release", pin_pull_low[39:32], 0);

        // R3 inverted readback, two-edge latency
        pin_in[15:8] = 8'h3C;
        @(negedge clk);
        rd(data_off(1), d); chk(d == 8'h00, "R3 before sync", d, 8'h00);
        @(negedge clk);
        rd(data_off(1), d); chk(d == 8'hC3, "R3 inverted", d, 8'hC3);
        pin_in[15:8] = 8'hFF;
        repeat (3) @(negedge clk);

        // R4 page/lock readback, R6 lock
        wr(OFF_PGLK, 8'h84);
        rd(OFF_PGLK, d); chk(d == 8'h84, "R4 pagelock", d, 8'h84);
        wr(data_off(2), 8'hFF);
        chk(pin_pull_low[23:16] == 0, "R6 locked write", pin_pull_low[23:16], 0);
        wr(data_off(3), 8'h11);
        chk(pin_pull_low[31:24] == 8'h11, "R6 unlocked port", pin_pull_low[31:24], 8'h11);

        // R5 page select keeps locks
        wr(OFF_PGSEL, 8'd1);
        rd(OFF_PGLK, d); chk(d == 8'h44, "R5 page only", d, 8'h44);
        rd(OFF_PGSEL, d); chk(d == 0, "R5 pgsel reads 0", d, 0);
        rd(4'd12, d); chk(d == 0, "R5 unused offset", d, 0);
        wr(OFF_PGLK, 8'h00);
        wr(data_off(3), 8'h00);

        // R7 page 0 ignores paged writes
        wr(OFF_PGSEL, 8'd0);
        wr(paged_off(0), 8'hFF);
        wr(OFF_PGSEL, 8'd2);
        rd(paged_off(0), d); chk(d == 0, "R7 page0 write ignored", d, 0);
        wr(paged_off(0), 8'h0F); m_en[0] = 8'h0F;
        wr(OFF_PGSEL, 8'd1);
        wr(paged_off(0), 8'h05); m_pol[0] = 8'h05;
        rd(paged_off(0), d); chk(d == 8'h05, "R7 polarity bank", d, 8'h05);
        wr(OFF_PGSEL, 8'd2);
        rd(paged_off(0), d); chk(d == 8'h0F, "R7 enable bank", d, 8'h0F);

        // R8 directed: falling on bits 0..3 (rising on 0,2; falling on 1,3), bit 4 disabled
        v = pin_in; v[7:0] = 8'hE0;
        set_pins(v);
        check_ids("dir1");
        chk(m_id[0] == 8'h0A, "R8 directed model", m_id[0], 8'h0A);

        // R9 clear then edge in same cycle as clear
        wr(OFF_PGSEL, 8'd3);
        pin_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        wr(paged_off(0), 8'h00);
        rd(paged_off(0), d); chk(d == 8'h01, "R9 edge wins clear", d, 8'h01);
        m_id[0] = 8'h01;
        @(negedge clk);
        wr(paged_off(0), 8'hFE); m_id[0] = 0;
        rd(paged_off(0), d); chk(d == 0, "R9 mask clear", d, 0);
        chk(irq == 0, "R10 irq low after clear", irq, 0);
        rd(OFF_PEND, d); chk(d == 0, "R10 pending upper zero", d, 0);
        v = pin_in; v[7:0] = 8'hFF; set_pins(v);

        // R11 upper ports toggle without capture
        v = pin_in; v[47:24] = 24'h0;
        set_pins(v);
        v[47:24] = 24'hFFFFFF;
        set_pins(v);
        check_ids("R11");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int p = $urandom_range(0, 2);
            int op = $urandom_range(0, 5);
            if (op == 0) begin
                wr(OFF_PGSEL, 8'd1); d = 8'($urandom); wr(paged_off(p), d); m_pol[p] = d;
            end else if (op == 1) begin
                wr(OFF_PGSEL, 8'd2); d = 8'($urandom); wr(paged_off(p), d); m_en[p] = d;
            end else if (op == 2) begin
                wr(OFF_PGSEL, 8'd3); d = 8'($urandom); wr(paged_off(p), d); m_id[p] &= d;
            end else begin
                v = {$urandom, $urandom};
                set_pins(v);
            end
            if (it % 10 == 9) check_ids("rand");
        end
        check_ids("final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule